// File: doc/BRIEF.md
# Packed-word UART transmitter

This block is the transmit half of a serial port that sits behind a write-only 32-bit register port. Software first writes how many characters it wants to send. It then pushes 32-bit words into a word FIFO, and each word carries up to four characters. A character unpacker takes one word at a time from the FIFO. It releases the bytes low byte first to a serializer, which builds asynchronous frames on the line.

The frame layout comes from a frame register: 5 to 8 data bits, none/odd/even/space parity, and a stop length of 9/16, 1, 1+9/16 or 2 bit times. A bit lasts sixteen pulses of an external oversampling tick, which makes the fractional stop lengths exact. A line-control bit turns the serial stream away from the pin and onto an internal return path that feeds a receiver.

Status outputs tell software whether the FIFO has room and whether the whole path is empty. A raw interrupt vector, together with a mask register, drives one interrupt line. A command register enables or disables the transmitter, flushes it, and clears the sticky completion flag.

Top module: `pkuart_tx`

## Requirements
- R1: After reset: tx_o and loop_o are 1, txrdy_o and txemt_o are 1, irq_status_o is 0x081, irq_o is 0. The frame register resets to 0x34 (8 data bits, no parity, 1 stop bit). The interrupt mask and the watermark reset to 0, return routing is off and the transmitter is disabled.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. Every bit lasts 16 tick pulses. Frame register bits [5:4] hold a code 0..3 that selects 5, 6, 7 or 8 data bits. From idle, a character starts only on a tick.
- R3: Frame register bits [1:0] select the parity mode. Code 0 sends no parity bit. Code 1 sends odd parity, code 2 sends even parity, and code 3 sends a bit that is always 0. Parity covers only the data bits that are sent and follows the last data bit.
- R4: Frame register bits [3:2] select the stop length: code 0 is 9 ticks, code 1 is 16, code 2 is 25 and code 3 is 32. When another character is ready, its start bit follows the stop bit with no gap.
- R5: A write to address 5 sets the count of characters still to send. Each write to address 6 pushes one word. A word is sent from bits [7:0] upward, and only as many of its bytes as the count still allows. A word taken while the count is zero is dropped without being sent.
- R6: Command register (address 2) bit 2 enables the transmitter and bit 3 disables it; if both are set, disable wins. No character starts while the transmitter is disabled.
- R7: The command code is {bit 11, bits [7:4]}. Code 0x02 flushes the FIFO and the held word, clears the pending count and aborts the frame. tx_o is high from the next clock on, and nothing is sent afterwards.
- R8: Interrupt bit 9 (done) is set when a stop bit ends and the pending count is zero. It stays set until command code 0x11; other command codes leave it unchanged.
- R9: txrdy_o is 1 while the FIFO is not full, and a word pushed into a full FIFO is lost. txemt_o is 1 when the FIFO, the held word and the serializer are all empty.
- R10: Interrupt bit 0 is 1 while the FIFO level is less than or equal to the watermark (address 4). The level counts the words not yet taken by the unpacker, which holds one word. Bit 7 is 1 while the pending count is zero. irq_o is the OR of irq_status_o ANDed with the mask (address 3).
- R11: With line-control register (address 1) bit 7 set, the serial stream appears on loop_o and tx_o stays high. With the bit clear, the stream is on tx_o and loop_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| tx_o | output | 1 | Serial line to the pin |
| loop_o | output | 1 | Serial line returned to the receiver |
| txrdy_o | output | 1 | FIFO can accept a word |
| txemt_o | output | 1 | FIFO, held word and serializer all empty |
| irq_status_o | output | 10 | Raw interrupt bits (0 level, 7 count drained, 9 done) |
| irq_o | output | 1 | Masked interrupt |

## Verification
Random bursts step through every data width, parity mode and stop code, with random byte values and character counts that are not multiples of four. These runs separate errors in bit order, parity polarity and width masking from errors in stop timing; the stop timing is measured exactly between back-to-back characters. Directed cases cover the state-sensitive paths. A word written before any count shows that data is dropped. Filling the FIFO while the transmitter is disabled shows both the watermark level and the loss of a word pushed into a full FIFO. A flush issued in the middle of a frame shows that the line goes idle within one clock. Return routing separates the two line outputs.

// File: rtl/pkuart_pkg.sv
package pkuart_pkg;

  localparam int TICKS_PER_BIT = 16;
  localparam int TC_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int IRQ_W = 10;
  localparam int IRQ_LEV = 0;
  localparam int IRQ_RDY = 7;
  localparam int IRQ_DONE = 9;

  localparam logic [2:0] A_FRAME = 3'd0;
  localparam logic [2:0] A_LINE  = 3'd1;
  localparam logic [2:0] A_CMD   = 3'd2;
  localparam logic [2:0] A_MASK  = 3'd3;
  localparam logic [2:0] A_WMARK = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;
  localparam logic [2:0] A_WORD  = 3'd6;

  localparam logic [4:0] CMD_FLUSH    = 5'h02;
  localparam logic [4:0] CMD_CLR_DONE = 5'h11;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} ser_state_t;

  typedef struct packed {
    logic [1:0] dbits;
    logic [1:0] stop;
    logic [1:0] par;
  } frame_t;

  function automatic logic [3:0] bits_of(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic [TC_W-1:0] stop_len(input logic [1:0] code);
    case (code)
      2'd0:    return TC_W'((9 * TICKS_PER_BIT) / 16);
      2'd1:    return TC_W'(TICKS_PER_BIT);
      2'd2:    return TC_W'(TICKS_PER_BIT + (9 * TICKS_PER_BIT) / 16);
      default: return TC_W'(2 * TICKS_PER_BIT);
    endcase
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] bcode,
                                   input logic [1:0] pmode);
    logic [7:0] m;
    logic x;
    m = 8'hFF >> (2'd3 - bcode);
    x = ^(d & m);
    case (pmode)
      2'd1:    return ~x;
      2'd2:    return x;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pkuart_regs.sv
module pkuart_regs
  import pkuart_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [31:0]          wr_data,
  output frame_t               frame_o,
  output logic                 loop_en_o,
  output logic                 tx_en_o,
  output logic [IRQ_W-1:0]     mask_o,
  output logic [LVL_W-1:0]     wmark_o,
  output logic                 cnt_load_o,
  output logic [CNT_W-1:0]     cnt_val_o,
  output logic                 word_push_o,
  output logic [31:0]          word_o,
  output logic                 cmd_flush_o,
  output logic                 cmd_clr_done_o
);

  logic       wr_cmd;
  logic [4:0] cmd_code;

  assign wr_cmd   = wr_en && (wr_addr == A_CMD);
  assign cmd_code = {wr_data[11], wr_data[7:4]};

  assign cmd_flush_o    = wr_cmd && (cmd_code == CMD_FLUSH);
  assign cmd_clr_done_o = wr_cmd && (cmd_code == CMD_CLR_DONE);
  assign cnt_load_o     = wr_en && (wr_addr == A_COUNT);
  assign cnt_val_o      = wr_data[CNT_W-1:0];
  assign word_push_o    = wr_en && (wr_addr == A_WORD);
  assign word_o         = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o   <= '{dbits: 2'd3, stop: 2'd1, par: 2'd0};
      loop_en_o <= 1'b0;
      tx_en_o   <= 1'b0;
      mask_o    <= '0;
      wmark_o   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_FRAME: frame_o   <= frame_t'(wr_data[5:0]);
        A_LINE:  loop_en_o <= wr_data[7];
        A_MASK:  mask_o    <= wr_data[IRQ_W-1:0];
        A_WMARK: wmark_o   <= wr_data[LVL_W-1:0];
        A_CMD: begin
          if (wr_data[3])      tx_en_o <= 1'b0;
          else if (wr_data[2]) tx_en_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pkuart_fifo.sv
module pkuart_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

endmodule

// File: rtl/pkuart_ser.sv
module pkuart_ser
  import pkuart_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tx_en,
  input  frame_t           frame,
  input  logic             flush,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_dout,
  output logic             fifo_pop,
  output logic             serial,
  output logic             busy,
  output logic             hold_empty,
  output logic             cnt_zero,
  output logic             char_start,
  output logic             frame_end
);

  localparam logic [TC_W-1:0] BIT_LAST = TC_W'(TICKS_PER_BIT - 1);

  ser_state_t       state;
  logic [31:0]      hold_w;
  logic [2:0]       hold_n;
  logic [CNT_W-1:0] chars_left;
  logic [TC_W-1:0]  tcnt;
  logic [2:0]       bidx;
  logic [7:0]       sreg;
  logic             par_q;
  logic             can_start, bit_end;
  logic [2:0]       fetch_n;
  logic [2:0]       last_bit;

  assign cnt_zero   = (chars_left == '0);
  assign hold_empty = (hold_n == 3'd0);
  assign busy       = (state != ST_IDLE);
  assign can_start  = tx_en && !hold_empty;
  assign fetch_n    = (chars_left >= CNT_W'(4)) ? 3'd4 : chars_left[2:0];
  assign fifo_pop   = !flush && hold_empty && !fifo_empty;
  assign bit_end    = tick && (tcnt == BIT_LAST);
  assign last_bit   = 3'(bits_of(frame.dbits) - 4'd1);
  assign frame_end  = !flush && (state == ST_STOP) && tick &&
                      (tcnt == stop_len(frame.stop) - TC_W'(1));
  assign char_start = !flush && can_start &&
                      (((state == ST_IDLE) && tick) || frame_end);

  always_comb begin
    case (state)
      ST_START: serial = 1'b0;
      ST_DATA:  serial = sreg[0];
      ST_PAR:   serial = par_q;
      default:  serial = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hold_w     <= '0;
      hold_n     <= '0;
      chars_left <= '0;
      tcnt       <= '0;
      bidx       <= '0;
      sreg       <= '0;
      par_q      <= 1'b0;
    end else if (flush) begin
      state      <= ST_IDLE;
      hold_n     <= '0;
      chars_left <= '0;
      tcnt       <= '0;
    end else begin
      if (fifo_pop) begin
        hold_w <= fifo_dout;
        hold_n <= fetch_n;
      end
      if (char_start) begin
        sreg       <= hold_w[7:0];
        par_q      <= par_bit(hold_w[7:0], frame.dbits, frame.par);
        hold_w     <= hold_w >> 8;
        hold_n     <= hold_n - 3'd1;
        chars_left <= chars_left - CNT_W'(1);
        state      <= ST_START;
        tcnt       <= '0;
      end else begin
        case (state)
          ST_START: if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + TC_W'(1);
            if (bit_end) begin
              state <= ST_DATA;
              bidx  <= '0;
            end
          end
          ST_DATA: if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + TC_W'(1);
            if (bit_end) begin
              sreg <= sreg >> 1;
              if (bidx == last_bit) state <= (frame.par == 2'd0) ? ST_STOP : ST_PAR;
              else                  bidx  <= bidx + 3'd1;
            end
          end
          ST_PAR: if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + TC_W'(1);
            if (bit_end) state <= ST_STOP;
          end
          ST_STOP: if (tick) begin
            if (frame_end) begin
              tcnt  <= '0;
              state <= ST_IDLE;
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          default: ;
        endcase
      end
      if (cnt_load) chars_left <= cnt_val;
    end
  end

endmodule

// File: rtl/pkuart_tx.sv
module pkuart_tx
  import pkuart_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             tx_o,
  output logic             loop_o,
  output logic             txrdy_o,
  output logic             txemt_o,
  output logic [IRQ_W-1:0] irq_status_o,
  output logic             irq_o
);

  frame_t           frame;
  logic             loop_en, tx_en;
  logic [IRQ_W-1:0] mask;
  logic [LVL_W-1:0] wmark, level;
  logic             cnt_load, word_push, cmd_flush, cmd_clr_done;
  logic [CNT_W-1:0] cnt_val;
  logic [31:0]      word, fifo_dout;
  logic             fifo_full, fifo_empty, fifo_pop;
  logic             serial, busy, hold_empty, cnt_zero;
  logic             char_start, frame_end, done_evt, done_q;

  pkuart_regs #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_o(frame), .loop_en_o(loop_en), .tx_en_o(tx_en), .mask_o(mask),
    .wmark_o(wmark), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val),
    .word_push_o(word_push), .word_o(word), .cmd_flush_o(cmd_flush),
    .cmd_clr_done_o(cmd_clr_done)
  );

  pkuart_fifo #(.DEPTH(FIFO_DEPTH), .W(32), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_flush), .push(word_push), .din(word),
    .pop(fifo_pop), .dout(fifo_dout), .level(level), .full(fifo_full),
    .empty(fifo_empty)
  );

  pkuart_ser #(.CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .frame(frame),
    .flush(cmd_flush), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_pop(fifo_pop),
    .serial(serial), .busy(busy), .hold_empty(hold_empty), .cnt_zero(cnt_zero),
    .char_start(char_start), .frame_end(frame_end)
  );

  assign done_evt = frame_end && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_q <= 1'b0;
    else if (done_evt)     done_q <= 1'b1;
    else if (cmd_clr_done) done_q <= 1'b0;
  end

  always_comb begin
    irq_status_o           = '0;
    irq_status_o[IRQ_LEV]  = (level <= wmark);
    irq_status_o[IRQ_RDY]  = cnt_zero;
    irq_status_o[IRQ_DONE] = done_q;
  end

  assign irq_o   = |(irq_status_o & mask);
  assign txrdy_o = !fifo_full;
  assign txemt_o = fifo_empty && hold_empty && !busy;
  assign tx_o    = loop_en ? 1'b1 : serial;
  assign loop_o  = loop_en ? serial : 1'b1;

endmodule

// File: rtl/pkuart_chk.sv
module pkuart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_o,
  input logic loop_o,
  input logic loop_en,
  input logic txemt,
  input logic txrdy,
  input logic cmd_flush,
  input logic char_start,
  input logic frame_end,
  input logic cnt_zero,
  input logic done_bit
);

  AST_LINE_IDLE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (tx_o && loop_o)); // R7

  AST_EMPTY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    txemt |-> txrdy); // R9

  AST_START_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |-> !cnt_zero); // R5

  AST_DONE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cnt_zero) |=> done_bit); // R8

  AST_RETURN_PATH_QUIET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> tx_o); // R11

endmodule

bind pkuart_tx pkuart_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .loop_o(loop_o), .loop_en(loop_en),
  .txemt(txemt_o), .txrdy(txrdy_o), .cmd_flush(cmd_flush),
  .char_start(char_start), .frame_end(frame_end), .cnt_zero(cnt_zero),
  .done_bit(done_q)
);

// File: tb/test_pkuart_tx.sv
module test_pkuart_tx;

  localparam logic [2:0] RA_FRAME = 3'd0, RA_LINE = 3'd1, RA_CMD = 3'd2,
                         RA_MASK = 3'd3, RA_WMARK = 3'd4, RA_COUNT = 3'd5,
                         RA_WORD = 3'd6;

  logic        clk, rst_n, tick, wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        tx_o, loop_o, txrdy_o, txemt_o, irq_o;
  logic [9:0]  irq_status_o;

  int total = 0;
  int bad = 0;
  int mon_nd = 8;
  int mon_par = 0;
  int mon_stop = 1;
  bit mon_sel = 0;
  bit mon_off = 0;
  int burst_left = 0;
  int rx_count = 0;
  int tx_low_seen = 0;
  logic [7:0] exp_q[$];

  pkuart_tx i_pkuart_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_o(tx_o), .loop_o(loop_o), .txrdy_o(txrdy_o),
    .txemt_o(txemt_o), .irq_status_o(irq_status_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] width_mask(input int nd);
    return 8'hFF >> (8 - nd);
  endfunction

  function automatic logic want_parity(input logic [7:0] d, input int nd, input int pm);
    int ones = 0;
    for (int i = 0; i < nd; i++) ones += d[i];
    if (pm == 1) return (ones % 2 == 0);
    if (pm == 2) return (ones % 2 == 1);
    return 1'b0;
  endfunction

  function automatic int stop_clocks(input int code);
    case (code)
      0: return 18;
      1: return 32;
      2: return 50;
      default: return 64;
    endcase
  endfunction

  function automatic logic line_now();
    return mon_sel ? loop_o : tx_o;
  endfunction

  // serial monitor: decodes frames on the selected line
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && line_now() == 1'b0) begin
        bit more;
        more = 1'b1;
        while (more) begin
          logic [7:0] d;
          logic pb;
          int c;
          d = '0; pb = 1'b0; c = 0;
          repeat (16) @(negedge clk);
          if (!mon_off) chk(line_now() == 1'b0, "R2 start bit", line_now(), 0);
          for (int i = 0; i < mon_nd; i++) begin
            repeat (32) @(negedge clk);
            d[i] = line_now();
          end
          if (mon_par != 0) begin
            repeat (32) @(negedge clk);
            pb = line_now();
          end
          repeat (16) @(negedge clk);
          while (line_now() == 1'b1 && c < 100) begin
            c++;
            @(negedge clk);
          end
          rx_count++;
          if (!mon_off) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R5 unexpected character", d, 0);
            end else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(d == e, "R2 data bits", d, e);
              if (mon_par != 0)
                chk(pb == want_parity(e, mon_nd, mon_par), "R3 parity bit", pb,
                    want_parity(e, mon_nd, mon_par));
            end
            chk(c > 0, "R4 stop bit high", c, 1);
            if (burst_left > 0) burst_left--;
            if (burst_left > 0)
              chk(c == stop_clocks(mon_stop), "R4 stop length", c, stop_clocks(mon_stop));
          end
          more = (line_now() == 1'b0);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mon_sel && tx_o == 1'b0) tx_low_seen++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_frame(input int bcode, input int scode, input int pcode);
    mon_nd = 5 + bcode; mon_stop = scode; mon_par = pcode;
    wr(RA_FRAME, 32'((bcode << 4) | (scode << 2) | pcode));
  endtask

  task automatic push_chars(input int n);
    logic [7:0] b[];
    int nw;
    nw = (n + 3) / 4;
    b = new[nw * 4];
    for (int i = 0; i < nw * 4; i++) b[i] = 8'($urandom);
    for (int i = 0; i < n; i++) exp_q.push_back(b[i] & width_mask(mon_nd));
    burst_left = n;
    wr(RA_COUNT, 32'(n));
    for (int w = 0; w < nw; w++) wr(RA_WORD, {b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    @(negedge clk);
    while (!txemt_o && k < 40000) begin
      k++;
      @(negedge clk);
    end
    chk(txemt_o == 1'b1, tag, txemt_o, 1);
    repeat (120) @(negedge clk);
    chk(exp_q.size() == 0, "R5 every counted character sent", exp_q.size(), 0);
  endtask

  initial begin
    int rc;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(tx_o == 1'b1, "R1 tx idle", tx_o, 1);
    chk(loop_o == 1'b1, "R1 return idle", loop_o, 1);
    chk(txrdy_o == 1'b1, "R1 txrdy", txrdy_o, 1);
    chk(txemt_o == 1'b1, "R1 txemt", txemt_o, 1);
    chk(irq_status_o == 10'h081, "R1 irq status", irq_status_o, 10'h081);
    chk(irq_o == 1'b0, "R1 irq line", irq_o, 0);

    // R6: disabled after reset, nothing starts
    push_chars(1);
    repeat (400) @(negedge clk);
    chk(rx_count == 0, "R6 disabled after reset", rx_count, 0);
    chk(txemt_o == 1'b0, "R6 data held while disabled", txemt_o, 0);
    wr(RA_CMD, 32'h4);
    wait_idle("R6 sends once enabled");

    // R8: done set, other code keeps it, 0x11 clears it
    wr(RA_MASK, 32'h200);
    chk(irq_status_o[9] == 1'b1, "R8 done set", irq_status_o[9], 1);
    chk(irq_o == 1'b1, "R10 masked done raises irq", irq_o, 1);
    wr(RA_CMD, 32'h010);
    chk(irq_status_o[9] == 1'b1, "R8 other code keeps done", irq_status_o[9], 1);
    wr(RA_CMD, 32'h810);
    chk(irq_status_o[9] == 1'b0, "R8 clear done", irq_status_o[9], 0);
    chk(irq_o == 1'b0, "R10 irq follows mask", irq_o, 0);

    // R5: partial final word, default 8N1
    push_chars(6);
    wait_idle("R5 six chars drained");

    // R2 R3 R4: random bursts across frame settings
    for (int i = 0; i < 8; i++) begin
      set_frame((i / 2) % 4, (i * 3) % 4, i % 4);
      push_chars(2 + int'($urandom % 5));
      wait_idle("R4 burst drained");
    end
    set_frame(3, 1, 0);

    // R5: word with zero count is dropped
    rc = rx_count;
    wr(RA_WORD, 32'h5A5A5A5A);
    repeat (400) @(negedge clk);
    chk(rx_count == rc, "R5 word without count dropped", rx_count, rc);
    chk(txemt_o == 1'b1, "R5 dropped word leaves path empty", txemt_o, 1);

    // R6: disable, then enable+disable in one write
    wr(RA_CMD, 32'h8);
    push_chars(1);
    repeat (400) @(negedge clk);
    chk(rx_count == rc, "R6 disable holds character", rx_count, rc);
    wr(RA_CMD, 32'h4);
    wait_idle("R6 resumes");
    rc = rx_count;
    wr(RA_CMD, 32'hC);
    push_chars(1);
    repeat (400) @(negedge clk);
    chk(rx_count == rc, "R6 disable wins", rx_count, rc);
    wr(RA_CMD, 32'h4);
    wait_idle("R6 resumes again");

    // R10 R9: level, watermark and full FIFO while disabled
    wr(RA_CMD, 32'h8);
    wr(RA_WMARK, 32'd2);
    wr(RA_MASK, 32'h001);
    wr(RA_COUNT, 32'd40);
    for (int i = 0; i < 10; i++) begin
      logic [31:0] w;
      int lvl;
      w = $urandom;
      if (i < 9) for (int k = 0; k < 4; k++) exp_q.push_back(w[8*k +: 8]);
      wr(RA_WORD, w);
      @(negedge clk);
      lvl = (i < 8) ? i : 8;
      chk(irq_status_o[0] == (lvl <= 2), "R10 level vs watermark", irq_status_o[0], lvl <= 2);
      chk(irq_o == (lvl <= 2), "R10 masked level irq", irq_o, lvl <= 2);
      chk(txrdy_o == (lvl < 8), "R9 room flag", txrdy_o, lvl < 8);
    end
    burst_left = 36;
    wr(RA_CMD, 32'h4);
    wait_idle("R9 full fifo drains");
    chk(irq_status_o[7] == 1'b0, "R10 count still pending", irq_status_o[7], 0);
    wr(RA_CMD, 32'h020);
    chk(irq_status_o[7] == 1'b1, "R7 flush clears count", irq_status_o[7], 1);

    // R7: flush mid-frame
    mon_off = 1'b1;
    wr(RA_COUNT, 32'd8);
    wr(RA_WORD, 32'h11223344);
    wr(RA_WORD, 32'h55667788);
    rc = 0;
    while (tx_o == 1'b1 && rc < 4000) begin
      rc++;
      @(negedge clk);
    end
    repeat (50) @(negedge clk);
    chk(tx_o == 1'b0, "R7 frame in progress", tx_o, 0);
    wr(RA_CMD, 32'h020);
    chk(tx_o == 1'b1, "R7 line idle next clock", tx_o, 1);
    chk(txemt_o == 1'b1, "R7 fifo flushed", txemt_o, 1);
    rc = 0;
    repeat (600) begin
      @(negedge clk);
      if (tx_o == 1'b0) rc++;
    end
    chk(rc == 0, "R7 nothing sent after flush", rc, 0);
    exp_q.delete();
    burst_left = 0;
    mon_off = 1'b0;

    // R11: return routing
    wr(RA_LINE, 32'h80);
    mon_sel = 1'b1;
    tx_low_seen = 0;
    push_chars(3);
    wait_idle("R11 returned characters");
    chk(tx_low_seen == 0, "R11 pin stays high", tx_low_seen, 0);
    wr(RA_LINE, 32'h0);
    mon_sel = 1'b0;
    push_chars(2);
    wait_idle("R11 pin path restored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule